// File: doc/BRIEF.md
# Power Gating Sequence Controller

This controller stays powered at all times and moves a switchable logic domain between a running state and an unpowered state. Software or hardware asks for a change with a single-cycle pulse on one of two request inputs. The controller then drives a fixed chain of boundary controls. On the way down it gates the domain clocks, clamps the domain outputs, opens the ties between the two supply grids and turns off the main switch. On the way up it runs the same chain in reverse and holds the domain in reset. Each step that depends on slow hardware waits for an acknowledge: the clock controller, the grid-tie switches, or the domain power-good indication.

Every acknowledge wait is bounded by a timeout. When a timeout expires, the controller reports an error and freezes in the step where it stopped. A request that arrives in the middle of a sequence is stored. It is served once the controller reaches a settled state, either fully on or fully off. While the domain is leaving or entering the on state, the controller also asks for a slower always-on clock. A status code reports which phase the controller is in.

Top module: `pgs_top`

## Requirements
- R1: After reset the outputs are clkGateReq=0, isoClamp=0, tieClose=1, pwrSwOn=1, domRstN=1, slowClkReq=0 and seqStatus=0.
- R2: A power-down begins with clkGateReq=1 and slowClkReq=1. No further output changes until clkGateAck reads 1.
- R3: After clkGateAck, isoClamp rises one cycle before tieClose falls. The controller then waits for tieAck to read 0.
- R4: After tieAck reads 0, pwrSwOn and domRstN both fall. Once pwrGood reads 0, seqStatus becomes 2.
- R5: A power-up from the off state sets pwrSwOn=1 with domRstN held 0 and waits for pwrGood=1. It then sets tieClose=1 and waits for tieAck=1.
- R6: After tieAck=1, domRstN stays 0 for RST_HOLD more cycles. It then rises while isoClamp is still 1 and pwrGood is 1, so the reset covers at least RST_HOLD cycles of good power.
- R7: The cycle after domRstN rises, isoClamp falls. Then clkGateReq falls. Once clkGateAck reads 0, slowClkReq falls and seqStatus becomes 0.
- R8: If an awaited acknowledge is missing for TMO_CYC cycles, seqStatus becomes 4. It then keeps that value and all control outputs stay frozen until reset, even if the acknowledge arrives later.
- R9: A request pulse received during a sequence is held. It starts the opposite sequence as soon as the settled state is reached.
- R10: A request for the state the domain is already in (onReq while on, offReq while off) changes no output.
- R11: offReq and onReq pulsed in the same cycle while on is treated as a power-down request.
- R12: seqStatus encodes 0 = on, 1 = powering down, 2 = off, 3 = powering up, 4 = timeout error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| offReq | input | 1 | Single-cycle request to power the domain down |
| onReq | input | 1 | Single-cycle request to power the domain up |
| clkGateAck | input | 1 | Clock controller reports domain clocks stopped (1) or running (0) |
| tieAck | input | 1 | Grid-tie switches report closed (1) or open (0) |
| pwrGood | input | 1 | Domain supply is within range |
| clkGateReq | output | 1 | Request to stop the domain clocks |
| slowClkReq | output | 1 | Request for a slower always-on clock |
| isoClamp | output | 1 | Clamp domain outputs to fixed levels |
| tieClose | output | 1 | Close the ties between the two grids |
| pwrSwOn | output | 1 | Main supply switch enable |
| domRstN | output | 1 | Active-low reset to the domain |
| seqStatus | output | 3 | Phase code per R12 |

## Verification
The bench checks every change on the five boundary controls against an expected order. A design that swapped two steps, merged two steps into one cycle, or released the clamp before the reset would show an out-of-order or unexpected change. It queues a power-up request in the middle of a power-down and expects the full down-and-up chain. A controller that dropped the request would stop at off, and one that acted on it early would skip steps. It sends requests that match the current state and expects no output change. A design that restarted a sequence on such a request would toggle the clamp or the clocks. It withholds the clock acknowledge to force a timeout, then supplies the acknowledge late. A controller that resumed after the late acknowledge, or that flagged the error too early, would fail the status checks.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [3:0] {
    S_ON, S_DCLK, S_DISO, S_DTIE, S_DPWR, S_OFF,
    S_UPWR, S_UTIE, S_URST, S_UREL, S_UISO, S_UCLK
  } seqState_t;

  typedef struct packed {
    logic tmrClr;
    logic pendClr;
    logic errSet;
  } seqStrobe_t;

  localparam logic [2:0] STAT_ON   = 3'd0;
  localparam logic [2:0] STAT_DOWN = 3'd1;
  localparam logic [2:0] STAT_OFF  = 3'd2;
  localparam logic [2:0] STAT_UP   = 3'd3;
  localparam logic [2:0] STAT_ERR  = 3'd4;

endpackage

// File: rtl/pgs_dp.sv
module pgs_dp
  import pgs_pkg::*;
#(
  parameter int TMO_CYC  = 64,
  parameter int RST_HOLD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       offReq,
  input  logic       onReq,
  input  seqStrobe_t strobe,
  output logic       pendValid,
  output logic       pendOff,
  output logic       tmoHit,
  output logic       holdHit,
  output logic       errFlag
);

  localparam int CNT_TOP = (TMO_CYC > RST_HOLD) ? TMO_CYC : RST_HOLD;
  localparam int CW      = $clog2(CNT_TOP + 1);

  logic [CW-1:0] stepCnt;

  // step counter: restarts on every state change, saturates at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (strobe.tmrClr) begin
      stepCnt <= '0;
    end else if (stepCnt != CW'(CNT_TOP)) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign tmoHit  = (stepCnt == CW'(TMO_CYC - 1));
  assign holdHit = (stepCnt == CW'(RST_HOLD - 1));

  // pending request: a new pulse outranks the clear, off outranks on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendOff   <= 1'b0;
    end else if (offReq || onReq) begin
      pendValid <= 1'b1;
      pendOff   <= offReq;
    end else if (strobe.pendClr) begin
      pendValid <= 1'b0;
    end
  end

  // sticky timeout flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.errSet) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkGateAck,
  input  logic       tieAck,
  input  logic       pwrGood,
  input  logic       pendValid,
  input  logic       pendOff,
  input  logic       tmoHit,
  input  logic       holdHit,
  input  logic       errFlag,
  output seqStrobe_t strobe,
  output logic       clkGateReq,
  output logic       slowClkReq,
  output logic       isoClamp,
  output logic       tieClose,
  output logic       pwrSwOn,
  output logic       domRstN,
  output logic [2:0] seqStatus
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_ON;
    else       state <= nxt;
  end

  always_comb begin
    nxt            = state;
    strobe.errSet  = 1'b0;
    strobe.pendClr = 1'b0;
    if (!errFlag) begin
      unique case (state)
        S_ON: if (pendValid) begin
          strobe.pendClr = 1'b1;
          if (pendOff) nxt = S_DCLK;
        end
        S_OFF: if (pendValid) begin
          strobe.pendClr = 1'b1;
          if (!pendOff) nxt = S_UPWR;
        end
        S_DCLK: if (clkGateAck) nxt = S_DISO;
                else if (tmoHit) strobe.errSet = 1'b1;
        S_DISO: nxt = S_DTIE;
        S_DTIE: if (!tieAck) nxt = S_DPWR;
                else if (tmoHit) strobe.errSet = 1'b1;
        S_DPWR: if (!pwrGood) nxt = S_OFF;
                else if (tmoHit) strobe.errSet = 1'b1;
        S_UPWR: if (pwrGood) nxt = S_UTIE;
                else if (tmoHit) strobe.errSet = 1'b1;
        S_UTIE: if (tieAck) nxt = S_URST;
                else if (tmoHit) strobe.errSet = 1'b1;
        S_URST: if (holdHit) nxt = S_UREL;
        S_UREL: nxt = S_UISO;
        S_UISO: nxt = S_UCLK;
        S_UCLK: if (!clkGateAck) nxt = S_ON;
                else if (tmoHit) strobe.errSet = 1'b1;
        default: nxt = S_ON;
      endcase
    end
    strobe.tmrClr = (nxt != state);
  end

  // Moore decode of the boundary controls: {gate, slow, clamp, tie, switch, rstN}
  logic [5:0] ctl;
  always_comb begin
    unique case (state)
      S_ON:                 ctl = 6'b000111;
      S_DCLK:               ctl = 6'b110111;
      S_DISO:               ctl = 6'b111111;
      S_DTIE:               ctl = 6'b111011;
      S_DPWR, S_OFF:        ctl = 6'b111000;
      S_UPWR:               ctl = 6'b111010;
      S_UTIE, S_URST:       ctl = 6'b111110;
      S_UREL:               ctl = 6'b111111;
      S_UISO:               ctl = 6'b110111;
      S_UCLK:               ctl = 6'b010111;
      default:              ctl = 6'b000111;
    endcase
  end
  assign {clkGateReq, slowClkReq, isoClamp, tieClose, pwrSwOn, domRstN} = ctl;

  always_comb begin
    if (errFlag) seqStatus = STAT_ERR;
    else begin
      unique case (state)
        S_ON:  seqStatus = STAT_ON;
        S_OFF: seqStatus = STAT_OFF;
        S_DCLK, S_DISO, S_DTIE, S_DPWR: seqStatus = STAT_DOWN;
        default: seqStatus = STAT_UP;
      endcase
    end
  end

endmodule

// File: rtl/pgs_top.sv
module pgs_top
  import pgs_pkg::*;
#(
  parameter int TMO_CYC  = 64,
  parameter int RST_HOLD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       offReq,
  input  logic       onReq,
  input  logic       clkGateAck,
  input  logic       tieAck,
  input  logic       pwrGood,
  output logic       clkGateReq,
  output logic       slowClkReq,
  output logic       isoClamp,
  output logic       tieClose,
  output logic       pwrSwOn,
  output logic       domRstN,
  output logic [2:0] seqStatus
);

  seqStrobe_t strobe;
  logic pendValid, pendOff, tmoHit, holdHit, errFlag;

  pgs_dp #(.TMO_CYC(TMO_CYC), .RST_HOLD(RST_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .offReq(offReq), .onReq(onReq), .strobe(strobe),
    .pendValid(pendValid), .pendOff(pendOff), .tmoHit(tmoHit),
    .holdHit(holdHit), .errFlag(errFlag)
  );

  pgs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkGateAck(clkGateAck), .tieAck(tieAck),
    .pwrGood(pwrGood), .pendValid(pendValid), .pendOff(pendOff),
    .tmoHit(tmoHit), .holdHit(holdHit), .errFlag(errFlag), .strobe(strobe),
    .clkGateReq(clkGateReq), .slowClkReq(slowClkReq), .isoClamp(isoClamp),
    .tieClose(tieClose), .pwrSwOn(pwrSwOn), .domRstN(domRstN),
    .seqStatus(seqStatus)
  );

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic       clkGateReq,
  input logic       slowClkReq,
  input logic       isoClamp,
  input logic       tieClose,
  input logic       pwrSwOn,
  input logic       domRstN,
  input logic [2:0] seqStatus
);

  a_r2_gate_with_slow: assert property (@(posedge clk) disable iff (!rstN)
    clkGateReq |-> slowClkReq);

  a_r3_clamp_needs_gate: assert property (@(posedge clk) disable iff (!rstN)
    isoClamp |-> clkGateReq);

  a_r3_ties_open_under_clamp: assert property (@(posedge clk) disable iff (!rstN)
    !tieClose |-> isoClamp);

  a_r4_switch_off_ties_open: assert property (@(posedge clk) disable iff (!rstN)
    !pwrSwOn |-> (!tieClose && !domRstN));

  a_r6_release_under_clamp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(domRstN) |-> (isoClamp && pwrGood));

  a_r7_unclamp_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isoClamp) |-> domRstN);

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (seqStatus == 3'd4) |=> (seqStatus == 3'd4) && $stable(isoClamp) && $stable(pwrSwOn));

  a_r12_status_range: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus <= 3'd4);

endmodule

bind pgs_top pgs_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .clkGateReq(clkGateReq),
  .slowClkReq(slowClkReq), .isoClamp(isoClamp), .tieClose(tieClose),
  .pwrSwOn(pwrSwOn), .domRstN(domRstN), .seqStatus(seqStatus)
);

// File: tb/pgs_top_test.sv
`timescale 1ns/1ps
module pgs_top_test;

  localparam real CLK_PER  = 20.0;
  localparam int  TMO_CYC  = 16;
  localparam int  RST_HOLD = 5;
  localparam int  ENV_DLY  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic offReq = 1'b0, onReq = 1'b0;
  logic clkGateAck, tieAck, pwrGood;
  logic clkGateReq, slowClkReq, isoClamp, tieClose, pwrSwOn, domRstN;
  logic [2:0] seqStatus;
  logic envClkEn = 1'b1;

  int checks = 0;
  int errs = 0;

  always #(CLK_PER/2) clk = ~clk;

  pgs_top #(.TMO_CYC(TMO_CYC), .RST_HOLD(RST_HOLD)) uut (
    .clk(clk), .rstN(rstN), .offReq(offReq), .onReq(onReq),
    .clkGateAck(clkGateAck), .tieAck(tieAck), .pwrGood(pwrGood),
    .clkGateReq(clkGateReq), .slowClkReq(slowClkReq), .isoClamp(isoClamp),
    .tieClose(tieClose), .pwrSwOn(pwrSwOn), .domRstN(domRstN),
    .seqStatus(seqStatus)
  );

  // environment: each acknowledge follows its command after ENV_DLY cycles
  logic [3:0] cgCnt, tieCnt, pgCnt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkGateAck <= 1'b0; tieAck <= 1'b1; pwrGood <= 1'b1;
      cgCnt <= '0; tieCnt <= '0; pgCnt <= '0;
    end else begin
      if (envClkEn && clkGateAck != clkGateReq) begin
        if (cgCnt == 4'(ENV_DLY-1)) begin clkGateAck <= clkGateReq; cgCnt <= '0; end
        else cgCnt <= cgCnt + 1'b1;
      end else cgCnt <= '0;
      if (tieAck != tieClose) begin
        if (tieCnt == 4'(ENV_DLY-1)) begin tieAck <= tieClose; tieCnt <= '0; end
        else tieCnt <= tieCnt + 1'b1;
      end else tieCnt <= '0;
      if (pwrGood != pwrSwOn) begin
        if (pgCnt == 4'(ENV_DLY-1)) begin pwrGood <= pwrSwOn; pgCnt <= '0; end
        else pgCnt <= pgCnt + 1'b1;
      end else pgCnt <= '0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard of boundary control vectors {gate, clamp, tie, switch, rstN}
  logic [4:0] expQ[$];
  logic [4:0] prevVec;
  int holdCnt = 0;
  wire [4:0] curVec = {clkGateReq, isoClamp, tieClose, pwrSwOn, domRstN};

  always @(negedge clk) begin
    if (!rstN) begin
      prevVec = curVec;
      holdCnt = 0;
    end else begin
      if (curVec != prevVec) begin
        if (expQ.size() == 0) chk("R10 unexpected control change", {3'b0, curVec}, {3'b0, prevVec});
        else chk("R2-sequence order", {3'b0, curVec}, {3'b0, expQ.pop_front()});
        if (domRstN && !prevVec[0]) begin
          chk("R6 reset hold long enough", 8'(holdCnt >= RST_HOLD), 8'd1);
          chk("R6 clamp held at reset release", {7'b0, isoClamp}, 8'd1);
        end
        prevVec = curVec;
      end
      if (pwrGood && pwrSwOn && !domRstN) holdCnt++;
      else if (domRstN) holdCnt = 0;
    end
  end

  task automatic pushDown();
    expQ.push_back(5'b10111);
    expQ.push_back(5'b11111);
    expQ.push_back(5'b11011);
    expQ.push_back(5'b11000);
  endtask

  task automatic pushUp();
    expQ.push_back(5'b11010);
    expQ.push_back(5'b11110);
    expQ.push_back(5'b11111);
    expQ.push_back(5'b10111);
    expQ.push_back(5'b00111);
  endtask

  task automatic pulse(input logic doOff, input logic doOn);
    @(negedge clk);
    offReq = doOff; onReq = doOn;
    @(negedge clk);
    offReq = 1'b0; onReq = 1'b0;
  endtask

  task automatic waitStatus(input string req, input logic [2:0] target);
    for (int i = 0; i < 300; i++) begin
      if (seqStatus == target && expQ.size() == 0) break;
      @(negedge clk);
    end
    chk(req, {5'b0, seqStatus}, {5'b0, target});
    chk(req, 8'(expQ.size()), 8'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 controls", {3'b0, curVec}, 8'b00111);
    chk("R1 slow clock", {7'b0, slowClkReq}, 8'd0);
    chk("R12 status on", {5'b0, seqStatus}, 8'd0);

    // R10 onReq while on is ignored
    pulse(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R10 on while on", {5'b0, seqStatus}, 8'd0);

    // R2 R3 R4 power-down
    pushDown();
    pulse(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk("R2 slow clock asked", {7'b0, slowClkReq}, 8'd1);
    chk("R12 status going down", {5'b0, seqStatus}, 8'd1);
    waitStatus("R4 reaches off", 3'd2);

    // R10 offReq while off is ignored
    pulse(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 off while off", {5'b0, seqStatus}, 8'd2);

    // R5 R6 R7 power-up
    pushUp();
    pulse(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R12 status going up", {5'b0, seqStatus}, 8'd3);
    waitStatus("R7 reaches on", 3'd0);
    chk("R7 slow clock dropped", {7'b0, slowClkReq}, 8'd0);

    // R9 request queued in the middle of a power-down
    pushDown();
    pushUp();
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b1);
    chk("R9 still going down", {5'b0, seqStatus}, 8'd1);
    waitStatus("R9 pending served", 3'd0);

    // R11 both requests together while on
    pushDown();
    pulse(1'b1, 1'b1);
    waitStatus("R11 off wins", 3'd2);
    pushUp();
    pulse(1'b0, 1'b1);
    waitStatus("R11 back on", 3'd0);

    // R8 timeout on missing clock acknowledge
    envClkEn = 1'b0;
    expQ.push_back(5'b10111);
    pulse(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk("R8 no early error", {5'b0, seqStatus}, 8'd1);
    repeat (15) @(negedge clk);
    chk("R8 error flagged", {5'b0, seqStatus}, 8'd4);
    envClkEn = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 error sticky", {5'b0, seqStatus}, 8'd4);
    chk("R8 controls frozen", {3'b0, curVec}, 8'b10111);
    chk("R8 queue drained", 8'(expQ.size()), 8'd0);

    doReset();
    chk("R1 after second reset", {3'b0, curVec}, 8'b00111);
    chk("R12 status after reset", {5'b0, seqStatus}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule